// File: doc/BRIEF.md
# Horizontal Sync Edge Locator

This block sits behind the receiver of a parallel composite video link. It looks at every valid 10-bit sample and finds the falling edge of horizontal sync. A falling edge is the first sample below a fixed mid-level threshold that follows a sample at or above it. It keeps a local sample counter for a 910-sample line. While the counter is searching, each edge forces it to the reference position 785. Once edges have come back at the reference position on three lines in a row, the block declares lock. While it is locked, the counter runs freely and tracks how far edges have drifted from the expected position.

Downstream logic uses the reported sample index and the active-video flag to pick out picture samples. It uses the lock flag to decide whether that index can be trusted. The detector compares only against the threshold. Blanking, sync and burst levels that are off nominal, and 8-bit words padded with two zero LSBs, are handled the same way as nominal 10-bit codes.

Top module: `sync_locator`

## Requirements
- R1: After a synchronous reset, `line_idx` is 909, and `locked`, `sync_edge` and `active_video` are 0.
- R2: A valid sample is an edge when its value is below 080h and the previous valid sample was at or above 080h. A value of exactly 080h counts as high. `sync_edge` is 1 for exactly the one cycle after the clock edge that takes in that sample.
- R3: While `locked` is 0, an edge sample is given index 785. `line_idx` shows this one cycle after the sample is taken in.
- R4: Any other valid sample gets the previous index plus one, wrapping from 909 to 0. A cycle with `smp_valid` low leaves `line_idx` unchanged.
- R5: `locked` rises on the third edge of an unbroken chain. In that chain, every edge after the first lands on index 785 of the running count, so the edges are exactly 910 samples apart.
- R6: While searching, a sample whose running index is 785 but which is not an edge breaks the chain. Three new edges are then needed before lock.
- R7: While locked, an edge at any index other than 785 still pulses `sync_edge`. It does not change the counter.
- R8: While locked, two kinds of event count as errors: a sample at index 785 that is not an edge, and an edge at any other index. An edge at 785 clears the error count. The third consecutive error clears `locked` in the same cycle that the error is reported.
- R9: `active_video` is 1 exactly when `locked` is 1 and `line_idx` is below 768.
- R10: 8-bit samples carried in bits 9..2, with bits 1..0 zero, lock the same way as 10-bit samples. Off-nominal high levels, anywhere from 0A0h to 3A0h, and low levels, anywhere from 000h to 070h, do not disturb detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks a cycle that carries a sample |
| smp_data | input | 10 | Composite sample code |
| line_idx | output | 10 | Index of the last valid sample within the line |
| active_video | output | 1 | Last sample lies in the active picture while locked |
| locked | output | 1 | Line counter is locked to the incoming sync |
| sync_edge | output | 1 | Last sample was a falling sync edge |

## Verification
A misplaced edge and the loss of lock can fall on the same sample. When the third consecutive error is itself a stray sync pulse, the same cycle must raise `sync_edge`, drop `locked` and leave the counter on its free-running value instead of re-phasing it. The bench sets this up by sending two lines without sync to a locked block and then a line with an extra low pulse at position 300. It checks that the index reads 300 while the edge pulse is high and lock is low, and that the proper edge later in that line re-phases the counter as the start of a new chain.

// File: rtl/sync_pkg.sv
package sync_pkg;

    localparam int unsigned SMP_W      = 10;
    localparam int unsigned IDX_W      = 10;
    localparam int unsigned LINE_LEN   = 910;
    localparam int unsigned REF_POS    = 785;
    localparam int unsigned ACTIVE_LEN = 768;
    localparam int unsigned MID_LEVEL  = 10'h080;
    localparam int unsigned LOCK_RUN   = 3;
    localparam int unsigned LOSS_RUN   = 3;

    typedef enum logic {
        TRK_SEARCH = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] code;
    } sample_t;

    function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] cur,
                                                  input int unsigned len);
        if (cur == IDX_W'(len - 1))
            return '0;
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det
    import sync_pkg::*;
#(
    parameter int unsigned W      = SMP_W,
    parameter int unsigned THRESH = MID_LEVEL
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t smp,
    output logic    fall
);

    logic prev_high;
    logic now_high;

    assign now_high = (smp.code >= W'(THRESH));
    assign fall     = smp.valid && prev_high && !now_high;

    always_ff @(posedge clk) begin
        if (rst)
            prev_high <= 1'b0;
        else if (smp.valid)
            prev_high <= now_high;
    end

    // R2: an edge cannot follow a low sample
    p_edge_after_high_r2: assert property (@(posedge clk) disable iff (rst)
        (smp.valid && !now_high) |=> !fall);

endmodule

// File: rtl/sync_line_ctr.sv
module sync_line_ctr
    import sync_pkg::*;
#(
    parameter int unsigned W     = IDX_W,
    parameter int unsigned LEN   = LINE_LEN,
    parameter int unsigned REF_I = REF_POS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic         rephase,
    output logic [W-1:0] idx,
    output logic         at_ref
);

    localparam logic [W-1:0] LAST_IDX = W'(LEN - 1);
    localparam logic [W-1:0] REF_IDX  = W'(REF_I);

    logic [W-1:0] nxt;

    assign nxt    = (idx == LAST_IDX) ? '0 : idx + 1'b1;
    assign at_ref = (nxt == REF_IDX);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= LAST_IDX;
        else if (valid)
            idx <= rephase ? REF_IDX : nxt;
    end

    p_idx_in_line_r4: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);

    p_hold_without_valid_r4: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(idx));

    p_rephase_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && rephase) |=> idx == REF_IDX);

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !rephase && idx == LAST_IDX) |=> idx == '0);

endmodule

// File: rtl/sync_lock_trk.sv
module sync_lock_trk
    import sync_pkg::*;
#(
    parameter int unsigned GAIN_N = LOCK_RUN,
    parameter int unsigned LOSE_N = LOSS_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic fall,
    input  logic at_ref,
    output logic locked,
    output logic rephase
);

    localparam int unsigned GW = $clog2(GAIN_N + 1);
    localparam int unsigned MW = $clog2(LOSE_N + 1);

    trk_state_e    state;
    logic [GW-1:0] good_run;
    logic [MW-1:0] miss_run;

    assign locked  = (state == TRK_LOCKED);
    assign rephase = valid && fall && (state == TRK_SEARCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TRK_SEARCH;
            good_run <= '0;
            miss_run <= '0;
        end else if (valid) begin
            case (state)
                TRK_SEARCH: begin
                    if (fall) begin
                        if (good_run != '0 && at_ref) begin
                            if (good_run == GW'(GAIN_N - 1)) begin
                                state    <= TRK_LOCKED;
                                good_run <= '0;
                                miss_run <= '0;
                            end else begin
                                good_run <= good_run + 1'b1;
                            end
                        end else begin
                            good_run <= GW'(1);
                        end
                    end else if (at_ref) begin
                        good_run <= '0;
                    end
                end
                TRK_LOCKED: begin
                    if (fall && at_ref) begin
                        miss_run <= '0;
                    end else if (fall || at_ref) begin
                        if (miss_run == MW'(LOSE_N - 1)) begin
                            state    <= TRK_SEARCH;
                            miss_run <= '0;
                            good_run <= '0;
                        end else begin
                            miss_run <= miss_run + 1'b1;
                        end
                    end
                end
                default: state <= TRK_SEARCH;
            endcase
        end
    end

    p_lock_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (!locked && !(valid && fall)) |=> !locked);

    p_good_edge_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (locked && valid && fall && at_ref) |=> locked);

    p_no_rephase_locked_r7: assert property (@(posedge clk) disable iff (rst)
        locked |-> !rephase);

endmodule

// File: rtl/sync_locator.sv
module sync_locator
    import sync_pkg::*;
#(
    parameter int unsigned LINE_SAMPLES = LINE_LEN,
    parameter int unsigned EDGE_INDEX   = REF_POS,
    parameter int unsigned ACTIVE_SPAN  = ACTIVE_LEN,
    parameter int unsigned THRESHOLD    = MID_LEVEL,
    parameter int unsigned LOCK_LINES   = LOCK_RUN,
    parameter int unsigned LOSS_LINES   = LOSS_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic [IDX_W-1:0] line_idx,
    output logic             active_video,
    output logic             locked,
    output logic             sync_edge
);

    sample_t smp;
    logic    fall;
    logic    at_ref;
    logic    rephase;
    logic    lock_q;

    assign smp = '{valid: smp_valid, code: smp_data};

    sync_fall_det #(
        .W      (SMP_W),
        .THRESH (THRESHOLD)
    ) u_det (
        .clk  (clk),
        .rst  (rst),
        .smp  (smp),
        .fall (fall)
    );

    sync_line_ctr #(
        .W     (IDX_W),
        .LEN   (LINE_SAMPLES),
        .REF_I (EDGE_INDEX)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .rephase (rephase),
        .idx     (line_idx),
        .at_ref  (at_ref)
    );

    sync_lock_trk #(
        .GAIN_N (LOCK_LINES),
        .LOSE_N (LOSS_LINES)
    ) u_trk (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .fall    (fall),
        .at_ref  (at_ref),
        .locked  (lock_q),
        .rephase (rephase)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sync_edge <= 1'b0;
        else
            sync_edge <= fall;
    end

    assign locked       = lock_q;
    assign active_video = lock_q && (line_idx < IDX_W'(ACTIVE_SPAN));

    p_active_only_locked_r9: assert property (@(posedge clk) disable iff (rst)
        active_video |-> locked);

    p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_edge && !smp_valid) |=> !sync_edge);

    p_locked_runs_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && smp_valid) |=> line_idx == idx_step($past(line_idx), LINE_SAMPLES));

endmodule

// File: tb/sim_sync_locator.sv
`timescale 1ns/1ps
module sim_sync_locator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_data = '0;
    logic [9:0] line_idx;
    logic       active_video;
    logic       locked;
    logic       sync_edge;

    int n_chk = 0;
    int n_bad = 0;

    int m_idx, m_good, m_miss;
    bit m_lock, m_prevhi, m_edge;

    always #2.5 clk = ~clk;

    sync_locator u0 (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .line_idx     (line_idx),
        .active_video (active_video),
        .locked       (locked),
        .sync_edge    (sync_edge)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_idx = 909; m_good = 0; m_miss = 0;
        m_lock = 0; m_prevhi = 0; m_edge = 0;
    endtask

    task automatic model_step(input bit v, input int d);
        bit e, at, was_lock;
        int nxt;
        if (!v) begin
            m_edge = 0;
            return;
        end
        e = m_prevhi && (d < 128);
        m_prevhi = (d >= 128);
        nxt = (m_idx == 909) ? 0 : m_idx + 1;
        at = (nxt == 785);
        was_lock = m_lock;
        if (!m_lock) begin
            if (e) begin
                if (m_good != 0 && at) begin
                    if (m_good == 2) begin m_lock = 1; m_good = 0; m_miss = 0; end
                    else m_good++;
                end else m_good = 1;
            end else if (at) m_good = 0;
        end else begin
            if (e && at) m_miss = 0;
            else if (e || at) begin
                if (m_miss == 2) begin m_lock = 0; m_miss = 0; m_good = 0; end
                else m_miss++;
            end
        end
        m_idx = (!was_lock && e) ? 785 : nxt;
        m_edge = e;
    endtask

    task automatic put(input bit v, input int d);
        smp_valid = v;
        smp_data  = 10'(d);
        @(posedge clk);
        model_step(v, d);
        @(negedge clk);
        chk("R4 line_idx", int'(line_idx), m_idx);
        chk("R5 locked", int'(locked), int'(m_lock));
        chk("R2 sync_edge", int'(sync_edge), int'(m_edge));
        chk("R9 active_video", int'(active_video), int'(m_lock && m_idx < 768));
    endtask

    function automatic int gen(input int pos, input int extra, input bit sync_on, input bit eight);
        bit low;
        int v;
        low = (sync_on && pos >= 785 && pos <= 850) ||
              (extra > 0 && pos >= extra && pos < extra + 6);
        if (low) v = $urandom_range(0, 'h70);
        else if (pos >= 768) v = $urandom_range('h0A0, 'h150);
        else v = $urandom_range('h0A0, 'h3A0);
        if (eight) v = v & 'h3FC;
        return v;
    endfunction

    task automatic send(input int start, input int n, input int extra,
                        input bit sync_on, input bit eight);
        for (int k = 0; k < n; k++) begin
            int pos;
            pos = (start + k) % 910;
            if ($urandom_range(0, 7) == 0) put(0, $urandom_range(0, 1023));
            put(1, gen(pos, extra, sync_on, eight));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        chk("R1 idx", int'(line_idx), 909);
        chk("R1 locked", int'(locked), 0);
        chk("R1 edge", int'(sync_edge), 0);
        chk("R1 active", int'(active_video), 0);

        // threshold boundaries
        put(1, 'h100);
        put(1, 'h080);
        chk("R2 080h is high", int'(sync_edge), 0);
        put(1, 'h07F);
        chk("R2 edge below 080h", int'(sync_edge), 1);
        chk("R3 rephase to 785", int'(line_idx), 785);
        put(1, 'h081);
        chk("R4 next index", int'(line_idx), 786);
        put(1, 'h080);
        chk("R2 no edge at 080h", int'(sync_edge), 0);

        // lock acquisition
        do_reset();
        send(0, 910, 0, 1, 0);
        send(0, 910, 0, 1, 0);
        chk("R5 two edges not enough", int'(locked), 0);
        send(0, 910, 0, 1, 0);
        chk("R5 locked after third edge", int'(locked), 1);
        send(0, 910, 0, 1, 0);
        send(0, 910, 0, 1, 0);

        // misplaced edge while locked
        send(0, 301, 300, 1, 0);
        chk("R7 stray edge pulses", int'(sync_edge), 1);
        chk("R7 counter not rephased", int'(line_idx), 300);
        chk("R7 lock kept", int'(locked), 1);
        send(301, 609, 0, 1, 0);

        // error count cleared by good edge
        send(0, 910, 0, 0, 0);
        send(0, 910, 0, 0, 0);
        send(0, 910, 0, 1, 0);
        send(0, 910, 0, 0, 0);
        send(0, 910, 0, 0, 0);
        chk("R8 good edge cleared errors", int'(locked), 1);
        // third error is a stray edge: loss and edge in one cycle
        send(0, 301, 300, 1, 0);
        chk("R8 lock lost", int'(locked), 0);
        chk("R8 edge on loss", int'(sync_edge), 1);
        chk("R7 no rephase on loss", int'(line_idx), 300);
        send(301, 609, 0, 1, 0);

        // relock at a new phase
        send(400, 910, 0, 1, 0);
        send(400, 910, 0, 1, 0);
        send(400, 910, 0, 1, 0);
        chk("R5 relock at new phase", int'(locked), 1);

        // chain broken while searching
        do_reset();
        send(0, 910, 0, 1, 0);
        send(0, 910, 0, 0, 0);
        send(0, 910, 0, 1, 0);
        send(0, 910, 0, 1, 0);
        chk("R6 chain restarted", int'(locked), 0);
        send(0, 910, 0, 1, 0);
        chk("R6 lock after fresh chain", int'(locked), 1);

        // 8-bit words
        do_reset();
        for (int i = 0; i < 3; i++) send(0, 910, 0, 1, 1);
        chk("R10 8-bit lock", int'(locked), 1);
        send(0, 800, 0, 1, 1);
        chk("R10 8-bit edge index", int'(line_idx), 799);

        // random mix
        for (int i = 0; i < 6; i++) begin
            int ex;
            ex = ($urandom_range(0, 3) == 0) ? $urandom_range(10, 700) : 0;
            send(0, 910, ex, ($urandom_range(0, 3) != 0), $urandom_range(0, 1));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule